// File: doc/BRIEF.md
# Image Sensor Readout Timing Generator

This block drives the raster readout of a Bayer-patterned pixel array. On every data clock it says which array row and column to read, whether the current clock carries a pixel, and where the frame and the lines begin. It also produces a horizontal and a vertical sync. Each sync can be a programmable pulse or a level that marks valid data. The readout covers a programmable rectangle of the array. That rectangle can be decimated by 2, 4 or 8 in either direction without breaking the 2x2 colour quads. It can be read in reverse order horizontally, vertically or both.

Blank clocks follow the active pixels of a line, and blank lines follow the active lines of a frame. Both blank counts are floored at their legal minimums. An optional pad of fewer than one line's worth of clocks can be appended after the last blank line to trim the frame period finely. All settings arrive on plain input ports. The block latches them only at a frame boundary or in reset, so one frame always runs on one consistent geometry.

Top module: `sensor_readout_tg`

## Requirements
- R1: A line lasts (window width >> column skip code) + effective horizontal blank clocks. A frame lasts (window depth >> row skip code) + effective vertical blank lines, followed by the effective pad clocks.
- R2: A horizontal blank setting below 60 behaves as 60. A vertical blank setting below 4 behaves as 4.
- R3: `pix_valid` is high on the first (width >> column code) clocks of each of the first (depth >> row code) lines of a frame, and low at all other times. While `pix_valid` is low, both address outputs read 0.
- R4: Skip code 0, 1, 2 and 3 selects a factor of 1, 2, 4 and 8. The n-th address along an axis sits at offset 2^(code+1)*floor(n/2) + (n mod 2) from the first one, so two neighbouring addresses are read and then 2*(factor-1) are skipped.
- R5: The column start is taken with bit 0 cleared, so an unmirrored line begins on an even column.
- R6: With the flip bit of an axis clear, the addresses on that axis are start + offset. With it set, they are start + span - 1 - offset, so readout runs right to left or bottom to top.
- R7: In pulse mode, HSYNC is asserted on line clocks hs_start through hs_start + hs_width - 1 of every line, blank lines included.
- R8: In pulse mode, VSYNC is asserted for the whole of lines vs_start through vs_start + vs_width - 1.
- R9: In valid-level mode, HSYNC is asserted exactly when `pix_valid` is high, and VSYNC is asserted for the whole of every active line.
- R10: A sync whose active-low bit is 1 is driven inverted: its asserted state is 0.
- R11: The pad clocks follow the last blank line. During them `pix_valid` and `frame_start` are low and both syncs sit in their deasserted state. A pad setting at or above the line length acts as line length - 1.
- R12: `frame_start` is high for exactly the first clock of each frame.
- R13: Every setting is captured in reset and again at each frame boundary. A port change in mid-frame first shows in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous active-high reset |
| win_row_start | input | 11 | First array row of the window |
| win_col_start | input | 11 | First array column of the window (bit 0 ignored) |
| win_rows | input | 11 | Window depth in rows |
| win_cols | input | 11 | Window width in columns |
| row_skip | input | 2 | Row sub-sampling code |
| col_skip | input | 2 | Column sub-sampling code |
| row_flip | input | 1 | Read rows bottom to top |
| col_flip | input | 1 | Read columns right to left |
| hblank | input | 16 | Horizontal blank clocks per line |
| vblank | input | 13 | Vertical blank lines per frame |
| frame_pad | input | 14 | Extra clocks at the end of a frame |
| hs_start | input | 10 | HSYNC pulse start clock within a line |
| hs_width | input | 8 | HSYNC pulse width in clocks |
| hs_active_low | input | 1 | HSYNC polarity (1 = active low) |
| hs_valid_mode | input | 1 | HSYNC marks valid pixels instead of pulsing |
| vs_start | input | 10 | VSYNC pulse start line |
| vs_width | input | 8 | VSYNC pulse width in lines |
| vs_active_low | input | 1 | VSYNC polarity (1 = active low) |
| vs_valid_mode | input | 1 | VSYNC marks active lines instead of pulsing |
| row_addr | output | 11 | Array row being read |
| col_addr | output | 11 | Array column being read |
| pix_valid | output | 1 | Current clock carries a pixel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| frame_start | output | 1 | First clock of a frame |

## Verification
The scoreboard predicts every output on every clock of whole frames. It therefore catches an off-by-one in the line or frame length: such a fault slides `frame_start` and every later pixel by a clock or a line. The corner cases are these. Blank settings below the floor must still give a line of 60 blank clocks and 4 blank lines; a missing clamp shortens the frame. A pad set larger than a line must come out as one clock less than a line; a missing clamp makes the frame too long. An odd column start must not begin a line on a blue or green column. Mirrored readout under 4x and 8x skipping must step by one within a pair and jump by the full skip between pairs; a mirror that only reverses a unit step lands between quads. In one test the settings change in mid-frame, and the current frame must keep its old geometry; a design that samples its ports directly distorts that frame.

// File: rtl/sensor_tg_pkg.sv
package sensor_tg_pkg;

    localparam int ADDR_W    = 11;
    localparam int HBLK_W    = 16;
    localparam int VBLK_W    = 13;
    localparam int PAD_W     = 14;
    localparam int SYNC_WD_W = 8;
    localparam int SYNC_ST_W = 10;
    localparam int HCNT_W    = HBLK_W + 1;
    localparam int VCNT_W    = VBLK_W + 1;
    localparam int HBLK_MIN  = 60;
    localparam int VBLK_MIN  = 4;

    typedef logic [1:0] ss_code_t;

    // One readout axis: where it starts, how far it spans, decimation, direction.
    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] span;
        ss_code_t          code;
        logic              mirror;
    } axis_cfg_t;

    typedef struct packed {
        logic [SYNC_ST_W-1:0] start;
        logic [SYNC_WD_W-1:0] width;
        logic                 active_low;
        logic                 data_valid_mode;
    } sync_cfg_t;

    // Complete frame geometry, derived once and held for a whole frame.
    typedef struct packed {
        axis_cfg_t         col;
        axis_cfg_t         row;
        logic [ADDR_W-1:0] act_cols;
        logic [ADDR_W-1:0] act_rows;
        logic [HCNT_W-1:0] line_len;
        logic [VCNT_W-1:0] frame_lines;
        logic [PAD_W-1:0]  pad;
        sync_cfg_t         hs;
        sync_cfg_t         vs;
    } geom_t;

    function automatic logic [HBLK_W-1:0] hblank_floor(input logic [HBLK_W-1:0] hb);
        return (hb < HBLK_W'(HBLK_MIN)) ? HBLK_W'(HBLK_MIN) : hb;
    endfunction

    function automatic logic [VBLK_W-1:0] vblank_floor(input logic [VBLK_W-1:0] vb);
        return (vb < VBLK_W'(VBLK_MIN)) ? VBLK_W'(VBLK_MIN) : vb;
    endfunction

endpackage

// File: rtl/tg_raster.sv
module tg_raster
    import sensor_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HCNT_W-1:0] line_len,
    input  logic [VCNT_W-1:0] frame_lines,
    input  logic [PAD_W-1:0]  pad_len,
    output logic [HCNT_W-1:0] hcnt,
    output logic [VCNT_W-1:0] vcnt,
    output logic              in_pad,
    output logic              line_end,
    output logic              frame_wrap
);

    logic [PAD_W-1:0] pcnt;
    logic             last_line;

    always_comb begin
        line_end  = !in_pad && (hcnt == line_len - HCNT_W'(1));
        last_line = (vcnt == frame_lines - VCNT_W'(1));
        if (in_pad)
            frame_wrap = (pcnt == pad_len - PAD_W'(1));
        else
            frame_wrap = line_end && last_line && (pad_len == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || frame_wrap) begin
            hcnt   <= '0;
            vcnt   <= '0;
            in_pad <= 1'b0;
            pcnt   <= '0;
        end else if (in_pad) begin
            pcnt <= pcnt + PAD_W'(1);
        end else if (line_end) begin
            hcnt <= '0;
            if (last_line) begin
                in_pad <= 1'b1;
                pcnt   <= '0;
            end else begin
                vcnt <= vcnt + VCNT_W'(1);
            end
        end else begin
            hcnt <= hcnt + HCNT_W'(1);
        end
    end

    AST_HBLANK_FLOOR: assert property (@(posedge clk) disable iff (rst) line_end |-> (hcnt >= HCNT_W'(HBLK_MIN - 1))); // R2
    AST_PAD_UNDER_LINE: assert property (@(posedge clk) disable iff (rst) in_pad |-> (HCNT_W'(pcnt) < line_len)); // R11

endmodule

// File: rtl/tg_bayer_step.sv
module tg_bayer_step
    import sensor_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              advance,
    input  axis_cfg_t         ld,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;
    logic              odd_q;
    ss_code_t          code_q;
    logic              mir_q;
    logic [ADDR_W-1:0] step;

    // Inside a pair the step is one; leaving a pair it jumps over the skipped quads.
    always_comb begin
        step = odd_q ? ((ADDR_W'(2) << code_q) - ADDR_W'(1)) : ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            addr_q <= ld.mirror ? (ld.start + ld.span - ADDR_W'(1)) : ld.start;
            odd_q  <= 1'b0;
            code_q <= ld.code;
            mir_q  <= ld.mirror;
        end else if (advance) begin
            addr_q <= mir_q ? (addr_q - step) : (addr_q + step);
            odd_q  <= ~odd_q;
        end
    end

    assign addr = addr_q;

    AST_PAIR_UNIT_STEP: assert property (@(posedge clk) disable iff (rst) (advance && !restart && !odd_q) |=> (addr_q == (mir_q ? $past(addr_q) - ADDR_W'(1) : $past(addr_q) + ADDR_W'(1)))); // R4

endmodule

// File: rtl/tg_sync_gen.sv
module tg_sync_gen
    import sensor_tg_pkg::*;
#(
    parameter int POS_W = HCNT_W
) (
    input  logic [POS_W-1:0] pos,
    input  logic             enable,
    input  logic             valid_level,
    input  sync_cfg_t        cfg,
    output logic             sync_o
);

    localparam int EW = POS_W + 1;

    logic [EW-1:0] p_ext;
    logic [EW-1:0] lo;
    logic [EW-1:0] hi;
    logic          in_window;
    logic          asserted;

    always_comb begin
        p_ext     = EW'(pos);
        lo        = EW'(cfg.start);
        hi        = lo + EW'(cfg.width);
        in_window = (p_ext >= lo) && (p_ext < hi);
        asserted  = enable && (cfg.data_valid_mode ? valid_level : in_window);
        sync_o    = asserted ^ cfg.active_low;
    end

endmodule

// File: rtl/sensor_readout_tg.sv
module sensor_readout_tg
    import sensor_tg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    win_row_start,
    input  logic [ADDR_W-1:0]    win_col_start,
    input  logic [ADDR_W-1:0]    win_rows,
    input  logic [ADDR_W-1:0]    win_cols,
    input  logic [1:0]           row_skip,
    input  logic [1:0]           col_skip,
    input  logic                 row_flip,
    input  logic                 col_flip,
    input  logic [HBLK_W-1:0]    hblank,
    input  logic [VBLK_W-1:0]    vblank,
    input  logic [PAD_W-1:0]     frame_pad,
    input  logic [SYNC_ST_W-1:0] hs_start,
    input  logic [SYNC_WD_W-1:0] hs_width,
    input  logic                 hs_active_low,
    input  logic                 hs_valid_mode,
    input  logic [SYNC_ST_W-1:0] vs_start,
    input  logic [SYNC_WD_W-1:0] vs_width,
    input  logic                 vs_active_low,
    input  logic                 vs_valid_mode,
    output logic [ADDR_W-1:0]    row_addr,
    output logic [ADDR_W-1:0]    col_addr,
    output logic                 pix_valid,
    output logic                 hsync,
    output logic                 vsync,
    output logic                 frame_start
);

    geom_t             geom_in;
    geom_t             cur;
    geom_t             cfg_ld;
    logic [HBLK_W-1:0] hb_eff;
    logic [VBLK_W-1:0] vb_eff;

    logic [HCNT_W-1:0] hcnt;
    logic [VCNT_W-1:0] vcnt;
    logic              in_pad;
    logic              line_end;
    logic              frame_wrap;

    logic              row_active;
    logic              col_active;
    logic              valid_int;
    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] col_q;

    // Geometry as the ports describe it now.
    always_comb begin
        hb_eff = hblank_floor(hblank);
        vb_eff = vblank_floor(vblank);

        geom_in.col.start   = {win_col_start[ADDR_W-1:1], 1'b0};
        geom_in.col.span    = win_cols;
        geom_in.col.code    = col_skip;
        geom_in.col.mirror  = col_flip;
        geom_in.row.start   = win_row_start;
        geom_in.row.span    = win_rows;
        geom_in.row.code    = row_skip;
        geom_in.row.mirror  = row_flip;
        geom_in.act_cols    = win_cols >> col_skip;
        geom_in.act_rows    = win_rows >> row_skip;
        geom_in.line_len    = HCNT_W'(geom_in.act_cols) + HCNT_W'(hb_eff);
        geom_in.frame_lines = VCNT_W'(geom_in.act_rows) + VCNT_W'(vb_eff);
        if (HCNT_W'(frame_pad) >= geom_in.line_len)
            geom_in.pad = PAD_W'(geom_in.line_len - HCNT_W'(1));
        else
            geom_in.pad = frame_pad;
        geom_in.hs.start           = hs_start;
        geom_in.hs.width           = hs_width;
        geom_in.hs.active_low      = hs_active_low;
        geom_in.hs.data_valid_mode = hs_valid_mode;
        geom_in.vs.start           = vs_start;
        geom_in.vs.width           = vs_width;
        geom_in.vs.active_low      = vs_active_low;
        geom_in.vs.data_valid_mode = vs_valid_mode;
    end

    // Frame-held copy, refreshed only in reset and on the frame boundary.
    always_ff @(posedge clk) begin
        if (rst || frame_wrap)
            cur <= geom_in;
    end

    assign cfg_ld = (rst || frame_wrap) ? geom_in : cur;

    tg_raster u_raster (
        .clk         (clk),
        .rst         (rst),
        .line_len    (cur.line_len),
        .frame_lines (cur.frame_lines),
        .pad_len     (cur.pad),
        .hcnt        (hcnt),
        .vcnt        (vcnt),
        .in_pad      (in_pad),
        .line_end    (line_end),
        .frame_wrap  (frame_wrap)
    );

    always_comb begin
        row_active = (vcnt < VCNT_W'(cur.act_rows));
        col_active = (hcnt < HCNT_W'(cur.act_cols));
        valid_int  = !in_pad && row_active && col_active;
    end

    tg_bayer_step u_col_step (
        .clk     (clk),
        .rst     (rst),
        .restart (line_end || frame_wrap),
        .advance (valid_int),
        .ld      (cfg_ld.col),
        .addr    (col_q)
    );

    tg_bayer_step u_row_step (
        .clk     (clk),
        .rst     (rst),
        .restart (frame_wrap),
        .advance (line_end && row_active),
        .ld      (cfg_ld.row),
        .addr    (row_q)
    );

    tg_sync_gen #(.POS_W(HCNT_W)) u_hsync (
        .pos         (hcnt),
        .enable      (!in_pad),
        .valid_level (valid_int),
        .cfg         (cur.hs),
        .sync_o      (hsync)
    );

    tg_sync_gen #(.POS_W(VCNT_W)) u_vsync (
        .pos         (vcnt),
        .enable      (!in_pad),
        .valid_level (row_active),
        .cfg         (cur.vs),
        .sync_o      (vsync)
    );

    assign pix_valid   = valid_int;
    assign row_addr    = valid_int ? row_q : '0;
    assign col_addr    = valid_int ? col_q : '0;
    assign frame_start = !in_pad && (hcnt == '0) && (vcnt == '0);

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (rst) frame_start |=> !frame_start); // R12
    AST_EVEN_FIRST_COL: assert property (@(posedge clk) disable iff (rst) (pix_valid && (hcnt == '0) && !cur.col.mirror) |-> !col_addr[0]); // R5
    AST_COL_IN_WINDOW: assert property (@(posedge clk) disable iff (rst) pix_valid |-> ((col_addr >= cur.col.start) && (col_addr <= cur.col.start + cur.col.span - ADDR_W'(1)))); // R4
    AST_PAD_QUIET: assert property (@(posedge clk) disable iff (rst) in_pad |-> (!pix_valid && !frame_start && (hsync == cur.hs.active_low) && (vsync == cur.vs.active_low))); // R11
    AST_CFG_FRAME_HELD: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(frame_wrap)) |-> $stable(cur)); // R13

endmodule

// File: tb/sensor_readout_tg_bench.sv
module sensor_readout_tg_bench;
    import sensor_tg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [ADDR_W-1:0]    win_row_start, win_col_start, win_rows, win_cols;
    logic [1:0]           row_skip, col_skip;
    logic                 row_flip, col_flip;
    logic [HBLK_W-1:0]    hblank;
    logic [VBLK_W-1:0]    vblank;
    logic [PAD_W-1:0]     frame_pad;
    logic [SYNC_ST_W-1:0] hs_start, vs_start;
    logic [SYNC_WD_W-1:0] hs_width, vs_width;
    logic                 hs_active_low, hs_valid_mode, vs_active_low, vs_valid_mode;
    logic [ADDR_W-1:0]    row_addr, col_addr;
    logic                 pix_valid, hsync, vsync, frame_start;

    always #(CLK_PERIOD/2) clk = ~clk;

    sensor_readout_tg u_sensor_readout_tg (
        .clk(clk), .rst(rst),
        .win_row_start(win_row_start), .win_col_start(win_col_start),
        .win_rows(win_rows), .win_cols(win_cols),
        .row_skip(row_skip), .col_skip(col_skip),
        .row_flip(row_flip), .col_flip(col_flip),
        .hblank(hblank), .vblank(vblank), .frame_pad(frame_pad),
        .hs_start(hs_start), .hs_width(hs_width),
        .hs_active_low(hs_active_low), .hs_valid_mode(hs_valid_mode),
        .vs_start(vs_start), .vs_width(vs_width),
        .vs_active_low(vs_active_low), .vs_valid_mode(vs_valid_mode),
        .row_addr(row_addr), .col_addr(col_addr), .pix_valid(pix_valid),
        .hsync(hsync), .vsync(vsync), .frame_start(frame_start)
    );

    typedef struct {
        int rs, cs, rows, cols, rcode, ccode, rflip, cflip;
        int hb, vb, pad, hss, hsw, hsl, hsv, vss, vsw, vsl, vsv;
    } tcfg_t;

    typedef struct {
        bit fs, pv, hs, vs;
        int row, col;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    string tag    = "";

    task automatic chk(string req, string name, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL [%s] %s %s: actual %0d expected %0d", tag, req, name, act, exp);
        end
    endtask

    task automatic compare(item_t e);
        chk("R12", "frame_start", int'(frame_start), int'(e.fs));
        chk("R3", "pix_valid", int'(pix_valid), int'(e.pv));
        chk("R4 R6", "row_addr", int'(row_addr), e.row);
        chk("R4 R5 R6", "col_addr", int'(col_addr), e.col);
        chk("R7 R9 R10", "hsync", int'(hsync), int'(e.hs));
        chk("R8 R9 R10", "vsync", int'(vsync), int'(e.vs));
    endtask

    // Offset of the n-th read along an axis: pairs spaced 2^(code+1) apart.
    function automatic int bayer_off(int n, int code);
        return (n / 2) * (2 * (1 << code)) + (n % 2);
    endfunction

    task automatic apply(tcfg_t c);
        win_row_start = ADDR_W'(c.rs);
        win_col_start = ADDR_W'(c.cs);
        win_rows      = ADDR_W'(c.rows);
        win_cols      = ADDR_W'(c.cols);
        row_skip      = 2'(c.rcode);
        col_skip      = 2'(c.ccode);
        row_flip      = 1'(c.rflip);
        col_flip      = 1'(c.cflip);
        hblank        = HBLK_W'(c.hb);
        vblank        = VBLK_W'(c.vb);
        frame_pad     = PAD_W'(c.pad);
        hs_start      = SYNC_ST_W'(c.hss);
        hs_width      = SYNC_WD_W'(c.hsw);
        hs_active_low = 1'(c.hsl);
        hs_valid_mode = 1'(c.hsv);
        vs_start      = SYNC_ST_W'(c.vss);
        vs_width      = SYNC_WD_W'(c.vsw);
        vs_active_low = 1'(c.vsl);
        vs_valid_mode = 1'(c.vsv);
    endtask

    // Driver side of the scoreboard: one expected item per clock of a frame.
    task automatic push_frame(tcfg_t c);
        int cs0   = c.cs & ~1;                         // R5
        int hb    = (c.hb < 60) ? 60 : c.hb;           // R2
        int vb    = (c.vb < 4) ? 4 : c.vb;             // R2
        int ocols = c.cols >> c.ccode;
        int orows = c.rows >> c.rcode;
        int line  = ocols + hb;                        // R1
        int lines = orows + vb;                        // R1
        int pad   = (c.pad >= line) ? line - 1 : c.pad; // R11
        for (int v = 0; v < lines; v++) begin
            for (int h = 0; h < line; h++) begin
                item_t it;
                bit hact, vact;
                it.fs = (v == 0) && (h == 0);
                it.pv = (v < orows) && (h < ocols);
                if (it.pv) begin
                    it.row = c.rflip ? c.rs + c.rows - 1 - bayer_off(v, c.rcode) : c.rs + bayer_off(v, c.rcode);
                    it.col = c.cflip ? cs0 + c.cols - 1 - bayer_off(h, c.ccode) : cs0 + bayer_off(h, c.ccode);
                    it.row = it.row & 'h7FF;
                    it.col = it.col & 'h7FF;
                end else begin
                    it.row = 0;
                    it.col = 0;
                end
                hact  = c.hsv ? it.pv : ((h >= c.hss) && (h < c.hss + c.hsw));
                vact  = c.vsv ? (v < orows) : ((v >= c.vss) && (v < c.vss + c.vsw));
                it.hs = hact ^ 1'(c.hsl);
                it.vs = vact ^ 1'(c.vsl);
                q.push_back(it);
            end
        end
        for (int p = 0; p < pad; p++) begin
            item_t it;
            it.fs  = 1'b0;
            it.pv  = 1'b0;
            it.row = 0;
            it.col = 0;
            it.hs  = 1'(c.hsl);
            it.vs  = 1'(c.vsl);
            q.push_back(it);
        end
    endtask

    // Monitor side: pop and compare on every falling edge outside reset.
    always @(negedge clk) begin
        if (!rst && q.size() != 0) begin
            item_t e;
            e = q.pop_front();
            compare(e);
        end
    end

    task automatic start_run(tcfg_t c, tcfg_t c2, bit change, int frames, string t);
        item_t e;
        @(negedge clk);
        apply(c);
        rst <= 1'b1;
        @(negedge clk);
        @(negedge clk);
        for (int f = 0; f < frames; f++) push_frame(c);
        if (change) push_frame(c2);
        // Reset state: settings were captured in reset, first clock of the frame shown (R13).
        tag = {t, " R13 reset"};
        e = q.pop_front();
        compare(e);
        tag = t;
        rst <= 1'b0;
        if (change) begin
            repeat (100) @(negedge clk);
            apply(c2); // mid-frame change must wait for the boundary (R13)
        end
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        tcfg_t ca, cb, cc, ce;
        // R1 R7 R8 R11 R12: plain window, pulse syncs, short pad.
        ca = '{rs:14, cs:14, rows:4, cols:8, rcode:0, ccode:0, rflip:0, cflip:0,
               hb:60, vb:4, pad:3, hss:2, hsw:5, hsl:0, hsv:0, vss:1, vsw:2, vsl:0, vsv:0};
        // R2 R5 R6 R9 R10 R11: clamps, odd start, both mirrors, valid-level syncs inverted.
        cb = '{rs:14, cs:15, rows:16, cols:32, rcode:1, ccode:2, rflip:1, cflip:1,
               hb:10, vb:1, pad:200, hss:0, hsw:1, hsl:1, hsv:1, vss:0, vsw:1, vsl:1, vsv:1};
        // R4 R6: 8x on both axes, column mirror only, no pad.
        cc = '{rs:20, cs:40, rows:32, cols:32, rcode:3, ccode:3, rflip:0, cflip:1,
               hb:60, vb:4, pad:0, hss:10, hsw:3, hsl:1, hsv:0, vss:3, vsw:1, vsl:0, vsv:0};
        // R4: 2x columns and 4x rows unmirrored, HSYNC pulse beyond the pixels.
        ce = '{rs:100, cs:200, rows:16, cols:16, rcode:2, ccode:1, rflip:0, cflip:0,
               hb:70, vb:5, pad:10, hss:30, hsw:8, hsl:0, hsv:0, vss:2, vsw:3, vsl:1, vsv:0};
        apply(ca);
        start_run(ca, ca, 1'b0, 2, "R1 R7 R8 R11 R12");
        start_run(cb, cb, 1'b0, 2, "R2 R5 R6 R9 R10 R11");
        start_run(cc, cc, 1'b0, 2, "R4 R6 R1");
        start_run(ce, ce, 1'b0, 2, "R4 R7 R8");
        start_run(ca, cc, 1'b1, 1, "R13 change");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL [watchdog] run did not finish within %0d clocks", WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule